// File: doc/BRIEF.md
# Subband Complex Demodulator and Remodulator

This block serves one channel of a converter that splits a wide useful band into equal-width subbands, one per channel, spread evenly across the band. Real samples of the channel arrive at the full sampling rate. A phase-accumulator oscillator produces a complex carrier at the channel's subband centre and mixes the samples down so that the subband sits on zero frequency, ready for the channel's external decimation and lowpass filtering.

A second, independent path takes the filtered complex baseband samples back. It first multiplies them by a programmable constant complex coefficient, normally exp(-j*dphi) with dphi = pi*B*(L-1) for normalized bandwidth B and filter length L. This removes the opposite phases that adjacent channels would otherwise show in their shared transition zones. It then mixes the result back up to the subband centre and gives a real sample that is summed with the other channels outside the block. When the centre of the useful band lies at a quarter of the sampling rate, a frequency word of 2^22 puts the carrier there. Filtering and decimation are not part of this block.

Top module: `sbd_demod`

## Requirements
- R1: While `rst` is high and after its release, `dn_valid` and `up_valid` are 0 and `dn_re`, `dn_im`, `up_out` are 0. Both oscillator phases restart at 0 and the rotation coefficient returns to (32767, 0).
- R2: Each path has its own 24-bit phase. The n-th accepted sample of a path since reset uses phase n*`freq_word` mod 2^24. The phase advances only on a cycle with that path's valid high. The carrier index k is the top 12 bits of the phase.
- R3: The carrier for index k is sin = round(32767*sin(2*pi*k/4096)) and cos = the sin value at index (k+1024) mod 4096. Rounding is half away from zero.
- R4: The down-mixed output for input x is `dn_re` = RS(x*cos) and `dn_im` = RS(-(x*sin)).
- R5: The rotated baseband for input (a, b) and coefficient (c, d) is r_re = RS(a*c - b*d) and r_im = RS(a*d + b*c).
- R6: The remodulated output is `up_out` = RS(r_re*cos - r_im*sin).
- R7: RS(v) adds 2^14, shifts arithmetically right by 15, and saturates to [-32768, 32767].
- R8: Each accepted sample gives exactly one output of its path, three cycles after the acceptance edge, with the matching valid high. No valid is raised otherwise.
- R9: While a path's valid output is low, its data outputs hold their last value.
- R10: A coefficient written with `rot_load` is used by every up-path sample accepted on later edges. A sample accepted on the same edge as the write still uses the previous coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 24 | Carrier phase increment per sample |
| in_valid | input | 1 | Real input sample present |
| in_sample | input | 16 | Real input sample, signed |
| bb_valid | input | 1 | Filtered baseband sample present |
| bb_re | input | 16 | Baseband real part, signed |
| bb_im | input | 16 | Baseband imaginary part, signed |
| rot_load | input | 1 | Write the rotation coefficient |
| rot_re | input | 16 | Rotation real part, signed Q1.15 |
| rot_im | input | 16 | Rotation imaginary part, signed Q1.15 |
| dn_valid | output | 1 | Down-mixed sample present |
| dn_re | output | 16 | Down-mixed real part |
| dn_im | output | 16 | Down-mixed imaginary part |
| up_valid | output | 1 | Remodulated sample present |
| up_out | output | 16 | Remodulated real sample |

## Verification
The assertions assume that reset lasts for at least one clock edge. They also assume that a zero input gives a zero output only while the sample value and its valid are known, so the three-cycle lookback is counted from the release of reset. The stimulus holds reset for several cycles and keeps `freq_word` constant between resets, so each sample's phase follows directly from its count since reset. It drives every sample with known values, including the most negative input, full-scale coefficients, and idle gaps between samples.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int SBD_DATA_W  = 16;
  localparam int SBD_COEF_W  = 16;
  localparam int SBD_PHASE_W = 24;
  localparam int SBD_ADDR_W  = 10;

  // quadrant of the carrier index: which half-wave and which slope
  typedef enum logic [1:0] {
    Q_RISE     = 2'd0,
    Q_FALL     = 2'd1,
    Q_NEG_RISE = 2'd2,
    Q_NEG_FALL = 2'd3
  } quad_e;
endpackage

// File: rtl/sbd_round_sat.sv
module sbd_round_sat #(
  parameter int IN_W  = 33,
  parameter int OUT_W = 16,
  parameter int SHIFT = 15
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int SUM_W = IN_W + 1;
  localparam logic signed [SUM_W-1:0] HALF =
    {{(SUM_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] MAXV =
    SUM_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] shr;

  assign sum = SUM_W'(din) + HALF;
  assign shr = sum >>> SHIFT;

  always_comb begin
    if (shr > MAXV)      dout = MAXV[OUT_W-1:0];
    else if (shr < MINV) dout = MINV[OUT_W-1:0];
    else                 dout = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/sbd_quarter_rom.sv
module sbd_quarter_rom #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [AMP_W-1:0]  data_a,
  output logic [AMP_W-1:0]  data_b
);
  localparam int  DEPTH  = 1 << ADDR_W;
  localparam real PEAK_R = (2.0 ** (AMP_W - 1)) - 1.0;
  localparam real TWO_PI = 6.283185307179586;

  logic [AMP_W-1:0] mem [DEPTH];

  // first quarter of one sine period, full-scale positive amplitude
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = AMP_W'($rtoi(PEAK_R * $sin(TWO_PI * i / (4.0 * DEPTH)) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data_a <= mem[addr_a];
    data_b <= mem[addr_b];
  end
endmodule

// File: rtl/sbd_nco.sv
module sbd_nco import sbd_pkg::*; #(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  input  logic [PHASE_W-1:0]      freq,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int IDX_W = ADDR_W + 2;
  localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1) << ADDR_W;
  localparam logic signed [AMP_W-1:0] PEAK = {1'b0, {(AMP_W-1){1'b1}}};

  logic [PHASE_W-1:0] acc;
  logic [ADDR_W-1:0]  rd_addr [2];
  logic [AMP_W-1:0]   rd_data [2];

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (advance) acc <= acc + freq;
  end

  // port 0 is the cosine (index shifted by a quarter period), port 1 the sine
  for (genvar g = 0; g < 2; g++) begin : g_port
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] pos;
    quad_e             quad;
    logic              mirror;
    logic              peak_q, neg_q;
    logic signed [AMP_W-1:0] mag, val;

    assign idx    = acc[PHASE_W-1 -: IDX_W] + ((g == 0) ? QUARTER : '0);
    assign quad   = quad_e'(idx[IDX_W-1 -: 2]);
    assign pos    = idx[ADDR_W-1:0];
    assign mirror = (quad == Q_FALL) || (quad == Q_NEG_FALL);
    assign rd_addr[g] = mirror ? (~pos + 1'b1) : pos;

    always_ff @(posedge clk) begin
      if (rst) begin
        peak_q <= 1'b0;
        neg_q  <= 1'b0;
      end else begin
        peak_q <= mirror && (pos == '0);
        neg_q  <= (quad == Q_NEG_RISE) || (quad == Q_NEG_FALL);
      end
    end

    assign mag = peak_q ? PEAK : $signed(rd_data[g]);
    assign val = neg_q ? -mag : mag;

    if (g == 0) begin : g_cos
      assign cos_o = val;
    end else begin : g_sin
      assign sin_o = val;
    end
  end

  sbd_quarter_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk    (clk),
    .addr_a (rd_addr[0]),
    .addr_b (rd_addr[1]),
    .data_a (rd_data[0]),
    .data_b (rd_data[1])
  );
endmodule

// File: rtl/sbd_demod.sv
module sbd_demod import sbd_pkg::*; #(
  parameter int DATA_W  = SBD_DATA_W,
  parameter int COEF_W  = SBD_COEF_W,
  parameter int PHASE_W = SBD_PHASE_W,
  parameter int ADDR_W  = SBD_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       freq_word,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     bb_valid,
  input  logic signed [DATA_W-1:0] bb_re,
  input  logic signed [DATA_W-1:0] bb_im,
  input  logic                     rot_load,
  input  logic signed [COEF_W-1:0] rot_re,
  input  logic signed [COEF_W-1:0] rot_im,
  output logic                     dn_valid,
  output logic signed [DATA_W-1:0] dn_re,
  output logic signed [DATA_W-1:0] dn_im,
  output logic                     up_valid,
  output logic signed [DATA_W-1:0] up_out
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [COEF_W-1:0] UNITY = {1'b0, {(COEF_W-1){1'b1}}};

  logic signed [COEF_W-1:0] cos_dn, sin_dn, cos_up, sin_up;

  sbd_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(COEF_W)) u_nco_dn (
    .clk(clk), .rst(rst), .advance(in_valid), .freq(freq_word),
    .cos_o(cos_dn), .sin_o(sin_dn)
  );

  sbd_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(COEF_W)) u_nco_up (
    .clk(clk), .rst(rst), .advance(bb_valid), .freq(freq_word),
    .cos_o(cos_up), .sin_o(sin_up)
  );

  // ---------------- down path ----------------
  logic                     dv1, dv2;
  logic signed [DATA_W-1:0] x_q;
  logic signed [PROD_W-1:0] pc_q, ps_q;
  logic signed [SUM_W-1:0]  pc_ext, ps_neg;
  logic signed [DATA_W-1:0] dn_re_nx, dn_im_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv1  <= 1'b0;
      dv2  <= 1'b0;
      x_q  <= '0;
      pc_q <= '0;
      ps_q <= '0;
    end else begin
      dv1  <= in_valid;
      dv2  <= dv1;
      x_q  <= in_sample;
      pc_q <= x_q * cos_dn;
      ps_q <= x_q * sin_dn;
    end
  end

  assign pc_ext = SUM_W'(pc_q);
  assign ps_neg = -(SUM_W'(ps_q));

  sbd_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .SHIFT(FRAC)) u_rs_dn_re (
    .din(pc_ext), .dout(dn_re_nx));
  sbd_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .SHIFT(FRAC)) u_rs_dn_im (
    .din(ps_neg), .dout(dn_im_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_re    <= '0;
      dn_im    <= '0;
    end else begin
      dn_valid <= dv2;
      if (dv2) begin
        dn_re <= dn_re_nx;
        dn_im <= dn_im_nx;
      end
    end
  end

  // ---------------- up path ----------------
  logic signed [COEF_W-1:0] rot_re_q, rot_im_q;
  logic signed [PROD_W-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [SUM_W-1:0]  rot_sum_re, rot_sum_im;
  logic signed [DATA_W-1:0] r_re_nx, r_im_nx, r_re_q, r_im_q;
  logic                     uv1, uv2;
  logic signed [PROD_W-1:0] uc_q, us_q;
  logic signed [SUM_W-1:0]  up_sum;
  logic signed [DATA_W-1:0] up_nx;

  // coefficient register: a sample accepted on the write edge sees the old value
  always_ff @(posedge clk) begin
    if (rst) begin
      rot_re_q <= UNITY;
      rot_im_q <= '0;
    end else if (rot_load) begin
      rot_re_q <= rot_re;
      rot_im_q <= rot_im;
    end
  end

  assign m_rr = bb_re * rot_re_q;
  assign m_ii = bb_im * rot_im_q;
  assign m_ri = bb_re * rot_im_q;
  assign m_ir = bb_im * rot_re_q;
  assign rot_sum_re = SUM_W'(m_rr) - SUM_W'(m_ii);
  assign rot_sum_im = SUM_W'(m_ri) + SUM_W'(m_ir);

  sbd_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .SHIFT(FRAC)) u_rs_rot_re (
    .din(rot_sum_re), .dout(r_re_nx));
  sbd_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .SHIFT(FRAC)) u_rs_rot_im (
    .din(rot_sum_im), .dout(r_im_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      uv1    <= 1'b0;
      uv2    <= 1'b0;
      r_re_q <= '0;
      r_im_q <= '0;
      uc_q   <= '0;
      us_q   <= '0;
    end else begin
      uv1    <= bb_valid;
      uv2    <= uv1;
      r_re_q <= r_re_nx;
      r_im_q <= r_im_nx;
      uc_q   <= r_re_q * cos_up;
      us_q   <= r_im_q * sin_up;
    end
  end

  assign up_sum = SUM_W'(uc_q) - SUM_W'(us_q);

  sbd_round_sat #(.IN_W(SUM_W), .OUT_W(DATA_W), .SHIFT(FRAC)) u_rs_up (
    .din(up_sum), .dout(up_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      up_valid <= 1'b0;
      up_out   <= '0;
    end else begin
      up_valid <= uv2;
      if (uv2) up_out <= up_nx;
    end
  end
endmodule

// File: rtl/sbd_demod_chk.sv
module sbd_demod_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_sample,
  input logic                     bb_valid,
  input logic signed [DATA_W-1:0] bb_re,
  input logic signed [DATA_W-1:0] bb_im,
  input logic                     dn_valid,
  input logic signed [DATA_W-1:0] dn_re,
  input logic signed [DATA_W-1:0] dn_im,
  input logic                     up_valid,
  input logic signed [DATA_W-1:0] up_out
);
  logic [1:0] since = 2'd0;
  logic       rst_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst)              since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
    rst_q <= rst;
  end

  // R1: the edge after a reset edge leaves both paths idle and cleared
  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!dn_valid && !up_valid && dn_re == '0 &&
                                     dn_im == '0 && up_out == '0)
        else $error("outputs not cleared by reset");
    end
  end

  assert_dn_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (dn_valid == $past(in_valid, 3)));

  assert_up_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (up_valid == $past(bb_valid, 3)));

  assert_dn_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && !dn_valid) |-> ($stable(dn_re) && $stable(dn_im)));

  assert_up_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && !up_valid) |-> $stable(up_out));

  assert_dn_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(in_valid && in_sample == '0, 3)) |->
      (dn_re == '0 && dn_im == '0));

  assert_up_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(bb_valid && bb_re == '0 && bb_im == '0, 3)) |->
      (up_out == '0));
endmodule

bind sbd_demod sbd_demod_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .bb_valid(bb_valid), .bb_re(bb_re), .bb_im(bb_im),
  .dn_valid(dn_valid), .dn_re(dn_re), .dn_im(dn_im),
  .up_valid(up_valid), .up_out(up_out)
);

// File: tb/sbd_demod_tb.sv
`timescale 1ns/1ps
module sbd_demod_tb;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [23:0]        freq_word = '0;
  logic               in_valid = 1'b0, bb_valid = 1'b0, rot_load = 1'b0;
  logic signed [15:0] in_sample = '0, bb_re = '0, bb_im = '0, rot_re = '0, rot_im = '0;
  logic               dn_valid, up_valid;
  logic signed [15:0] dn_re, dn_im, up_out;

  sbd_demod u_dut (
    .clk(clk), .rst(rst), .freq_word(freq_word),
    .in_valid(in_valid), .in_sample(in_sample),
    .bb_valid(bb_valid), .bb_re(bb_re), .bb_im(bb_im),
    .rot_load(rot_load), .rot_re(rot_re), .rot_im(rot_im),
    .dn_valid(dn_valid), .dn_re(dn_re), .dn_im(dn_im),
    .up_valid(up_valid), .up_out(up_out)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string tag, longint act, longint exp_v, string what);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
    end
  endtask

  // R7 rounding and saturation
  function automatic longint rs(longint v);
    longint t = (v + 64'sd16384) >>> 15;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  // R3 carrier value at 12-bit index k
  function automatic longint carrier(int k);
    real v = 32767.0 * $sin(2.0 * PI * (k % 4096) / 4096.0);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  // bench model state
  longint ph_dn = 0, ph_up = 0;
  longint rot_r = 32767, rot_i = 0;
  longint fw = 0;
  longint q_dr[$], q_di[$], q_up[$];
  int     q_dt[$], q_ut[$];
  string  q_dtag[$], q_utag[$];
  longint last_dr = 0, last_di = 0, last_up = 0;

  // output monitor away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      last_dr = 0; last_di = 0; last_up = 0;
    end else begin
      if (dn_valid) begin
        if (q_dr.size() == 0) check("R8", 1, 0, "dn_valid with no pending sample");
        else begin
          check("R8", cyc, q_dt.pop_front() + 3, "down latency");
          check(q_dtag[0], dn_re, q_dr.pop_front(), "dn_re");
          check(q_dtag.pop_front(), dn_im, q_di.pop_front(), "dn_im");
        end
        last_dr = dn_re; last_di = dn_im;
      end else begin
        check("R9", dn_re, last_dr, "dn_re hold");
        check("R9", dn_im, last_di, "dn_im hold");
      end
      if (up_valid) begin
        if (q_up.size() == 0) check("R8", 1, 0, "up_valid with no pending sample");
        else begin
          check("R8", cyc, q_ut.pop_front() + 3, "up latency");
          check(q_utag.pop_front(), up_out, q_up.pop_front(), "up_out");
        end
        last_up = up_out;
      end else begin
        check("R9", up_out, last_up, "up_out hold");
      end
    end
  end

  // one cycle of stimulus; expectations from R2..R7 and R10
  task automatic cycle(bit dv, longint x, bit uv, longint br, longint bi,
                       bit ld, longint lr, longint li, string dtag, string utag);
    int k;
    longint c, s, rr, ri;
    in_valid = dv; in_sample = 16'(x);
    bb_valid = uv; bb_re = 16'(br); bb_im = 16'(bi);
    rot_load = ld; rot_re = 16'(lr); rot_im = 16'(li);
    if (dv) begin
      k = int'(ph_dn >> 12);
      c = carrier(k + 1024); s = carrier(k);
      q_dr.push_back(rs(x * c));
      q_di.push_back(rs(-(x * s)));
      q_dt.push_back(cyc);
      q_dtag.push_back(dtag);
      ph_dn = (ph_dn + fw) & 64'hFFFFFF;
    end
    if (uv) begin
      rr = rs(br * rot_r - bi * rot_i);
      ri = rs(br * rot_i + bi * rot_r);
      k = int'(ph_up >> 12);
      c = carrier(k + 1024); s = carrier(k);
      q_up.push_back(rs(rr * c - ri * s));
      q_ut.push_back(cyc);
      q_utag.push_back(utag);
      ph_up = (ph_up + fw) & 64'hFFFFFF;
    end
    if (ld) begin rot_r = lr; rot_i = li; end
    @(negedge clk);
  endtask

  task automatic do_reset(longint f);
    repeat (5) cycle(0, 0, 0, 0, 0, 0, 0, 0, "R4", "R6");
    rst = 1'b1;
    freq_word = 24'(f);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fw = f; ph_dn = 0; ph_up = 0; rot_r = 32767; rot_i = 0;
    check("R1", dn_valid, 0, "dn_valid after reset");
    check("R1", up_valid, 0, "up_valid after reset");
    check("R1", dn_re, 0, "dn_re after reset");
    check("R1", dn_im, 0, "dn_im after reset");
    check("R1", up_out, 0, "up_out after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint freqs [11];
    logic [31:0] st = 32'h1234_5678;
    @(negedge clk);
    freqs[0] = 64'h400000;     // quarter of the sampling rate (R3)
    freqs[1] = 64'hFFFFFF;     // phase wraps every sample (R2)
    freqs[2] = 64'h0123AB;     // arbitrary word with gaps (R2)
    for (int k = 0; k < 8; k++)
      freqs[3 + k] = longint'($rtoi((0.1 + 0.05 * (2 * k + 1) / 16.0) * 16777216.0));

    for (int f = 0; f < 11; f++) begin
      real dphi;
      longint lr, li;
      string dtag, utag;
      do_reset(freqs[f]);
      dphi = PI * 0.0125 * 63.0 * (f + 1);
      lr = longint'($rtoi(32767.0 * $cos(dphi) + ((($cos(dphi)) >= 0.0) ? 0.5 : -0.5)));
      li = -longint'($rtoi(32767.0 * $sin(dphi) + ((($sin(dphi)) >= 0.0) ? 0.5 : -0.5)));
      for (int i = 0; i < 64; i++) begin
        longint x, br, bi;
        bit dv, uv, ld;
        st = st * 32'd1103515245 + 32'd12345; x  = longint'($signed(st[30:15]));
        st = st * 32'd1103515245 + 32'd12345; br = longint'($signed(st[30:15]));
        st = st * 32'd1103515245 + 32'd12345; bi = longint'($signed(st[30:15]));
        dv = (i % 5) != 3;
        uv = (i % 3) != 1;
        ld = (i == 12) || (i == 40);
        dtag = (f == 0) ? "R3" : ((f <= 2) ? "R2" : "R4");
        if (i == 12 || i == 13)      utag = "R10";   // same-edge write, then first new sample
        else if (i > 13)             utag = "R5";
        else                         utag = (f <= 2) ? "R2" : "R6";
        cycle(dv, x, uv, br, bi, ld, (i == 12) ? lr : 23170, (i == 12) ? li : -23170, dtag, utag);
      end
    end

    // R7 saturation corners at a quarter-rate carrier
    do_reset(64'h400000);
    cycle(0, 0, 0, 0, 0, 1, -32768, 32767, "R7", "R7");
    for (int i = 0; i < 8; i++) begin
      cycle(1, (i % 2) ? 32767 : -32768, 1,
            (i % 2) ? 32767 : -32768, (i < 4) ? -32768 : 32767, 0, 0, 0, "R7", "R7");
    end
    cycle(1, -32768, 1, -32768, -32768, 1, -32768, 0, "R7", "R10");
    cycle(1, 32767, 1, -32768, -32768, 0, 0, 0, "R7", "R7");
    cycle(1, 0, 1, 0, 0, 0, 0, 0, "R4", "R6");

    repeat (6) cycle(0, 0, 0, 0, 0, 0, 0, 0, "R4", "R6");
    check("R8", q_dr.size(), 0, "down samples without output");
    check("R8", q_up.size(), 0, "up samples without output");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule